// File: doc/BRIEF.md
# Bank-Interleaved Read-Current Command Loop Generator

This block is a stimulus sequencer for measuring the read current of a DDR3 device while all eight banks are interleaved. Once enabled, it plays a fixed command loop of twenty sub-loops. Each active sub-loop opens a bank, reads it with auto-precharge and then fills the rest of its slot with deselects. Activates are spaced by the row-to-row delay `rrd_in` (in clocks). Groups of four activates are paced by the four-activate window `faw_in` (in clocks). The loop lasts `4*faw_in` cycles and then starts again from the beginning.

For each cycle the generator drives the command pins, the bank field, a toggled row/column address field, A10 and a tag naming the read-data pattern that is expected. It also holds the data mask low and raises a strobe-active flag while a read burst is on the bus. The current sub-loop index and the cycle position within the loop are exported, so that an external reference can follow the sequence. All pins are plain control outputs that change every cycle. There is no handshake and no back-pressure: a consumer must take every cycle as it comes.

The timing values are checked and latched when `en` rises. A bad pair raises `cfg_err`, and the loop does not start until `en` is lowered and raised again.

Top module: `rdcur_pattern_gen`

## Requirements
- R1: While in reset or while `en` has been low at the last clock edge, the command is deselect ({cs_n,ras_n,cas_n,we_n} = 1000), `sub_idx` = 0, `loop_cyc` = 0 and `strobe_act` = 0.
- R2: After a clock edge that samples a rising `en` with a valid configuration, `loop_cyc` is 0 and `sub_idx` is 0. `loop_cyc` then rises by one per clock and returns to 0 after `4*faw_in - 1`.
- R3: Let a position within each quarter (`faw_in` cycles long) have slot k = position / `rrd_in`. For k < 4, offset 0 of the slot issues activate (0011), offset 1 issues read with auto-precharge (0101), and the remaining offsets issue deselect (1000).
- R4: `a10` is 1 exactly in cycles that issue the read command and 0 in all other cycles.
- R5: In quarters 0 and 2, slots 0..3 address banks 0..3. The idle tail of the quarter (slot index 4, from `4*rrd_in` to the end of the quarter, present only if `faw_in > 4*rrd_in`) issues deselect with bank field 3.
- R6: In quarters 1 and 3, slots 0..3 address banks 4..7, and the idle tail carries bank field 7.
- R7: `sub_idx` = 10*half + 5*(quarter mod 2) + slot. In the first half, an even `sub_idx` gives `addr` all zeros with `data_tag` 8'h00, and an odd `sub_idx` gives `addr` all ones with `data_tag` 8'h33. In the second half the parities swap.
- R8: `dm` is 0 in every cycle.
- R9: `strobe_act` is 1 in each read-command cycle and in the following BURST-1 (3 by default) cycles while the loop runs, and 0 otherwise.
- R10: If `rrd_in` < 2 or `faw_in` < 4*`rrd_in` when `en` rises, `cfg_err` is 1 from the next cycle for as long as `en` stays high. The output stays deselect with `loop_cyc` 0, even if the inputs later become valid.
- R11: Lowering `en` returns the outputs to deselect on the next cycle. Raising `en` again restarts the loop at sub-loop 0, cycle 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| en | input | 1 | run request; rising edge starts the loop |
| rrd_in | input | RRD_W | activate-to-activate spacing in clocks |
| faw_in | input | FAW_W | four-activate window in clocks |
| cs_n | output | 1 | chip select, active low |
| ras_n | output | 1 | row strobe, active low |
| cas_n | output | 1 | column strobe, active low |
| we_n | output | 1 | write enable, active low |
| bank | output | 3 | bank field |
| addr | output | ADDR_W | toggled row/column address field |
| a10 | output | 1 | auto-precharge address bit |
| data_tag | output | 8 | expected read-data pattern |
| dm | output | 1 | data mask level |
| strobe_act | output | 1 | read burst on the bus |
| cfg_err | output | 1 | rejected timing configuration |
| sub_idx | output | 5 | current sub-loop, 0..19 |
| loop_cyc | output | FAW_W+2 | cycle within the loop |

## Verification
The bench uses the default widths (6-bit spacing, 8-bit window) and sweeps small timing pairs: the minimum spacing 2 with a window that is exactly 4x (no idle tail) and one that is longer, plus spacings 3 and 4 with idle tails and with tight windows. Every cycle of two full loops per pair is compared against an arithmetic model, which reaches each loop wrap, every idle sub-loop and strobe bursts that run past the end of a slot. Invalid pairs on both sides of the limit, and enable toggling in the middle of a loop, cover the start and restart rules.

// File: rtl/rdcur_pkg.sv
package rdcur_pkg;
  typedef enum logic [3:0] {
    CMD_ACT = 4'b0011,
    CMD_RDA = 4'b0101,
    CMD_DES = 4'b1000
  } cmd_e;

  localparam logic [7:0] TAG_ZERO = 8'h00;
  localparam logic [7:0] TAG_ALT  = 8'h33;

  typedef struct packed {
    logic       act;
    logic       rd;
    logic [2:0] bank;
    logic [4:0] sub;
    logic       ones;
  } slot_t;
endpackage

// File: rtl/rdcur_loop_ctrl.sv
module rdcur_loop_ctrl #(
  parameter int RRD_W = 6,
  parameter int FAW_W = 8,
  localparam int CW = FAW_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [RRD_W-1:0] rrd_in,
  input  logic [FAW_W-1:0] faw_in,
  output logic             running,
  output logic [CW-1:0]    cyc,
  output logic [RRD_W-1:0] rrd_q,
  output logic [FAW_W-1:0] faw_q,
  output logic             cfg_err
);
  logic          en_q;
  logic [CW-1:0] rrd_x4, faw_x, last;
  logic          cfg_ok;

  assign rrd_x4 = CW'(rrd_in) << 2;
  assign faw_x  = CW'(faw_in);
  assign cfg_ok = (rrd_in >= RRD_W'(2)) && (faw_x >= rrd_x4);
  assign last   = {faw_q, 2'b00} - CW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      running <= 1'b0;
      cfg_err <= 1'b0;
      rrd_q   <= '0;
      faw_q   <= '0;
    end else begin
      en_q <= en;
      if (!en) begin
        running <= 1'b0;
        cfg_err <= 1'b0;
      end else if (!en_q) begin
        if (cfg_ok) begin
          running <= 1'b1;
          rrd_q   <= rrd_in;
          faw_q   <= faw_in;
        end else begin
          cfg_err <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en || !running) cyc <= '0;
    else if (cyc == last)           cyc <= '0;
    else                            cyc <= cyc + CW'(1);
  end
endmodule

// File: rtl/rdcur_slot_decode.sv
module rdcur_slot_decode
  import rdcur_pkg::*;
#(
  parameter int RRD_W = 6,
  parameter int FAW_W = 8,
  localparam int CW = FAW_W + 2,
  localparam int NSLOT = 4
) (
  input  logic [CW-1:0]    cyc,
  input  logic [RRD_W-1:0] rrd,
  input  logic [FAW_W-1:0] faw,
  output slot_t            slot
);
  logic [CW-1:0] faw_x, two_faw, rrd_x, c1, c2;
  logic          half, qtr;
  logic [NSLOT-1:0] hit;
  logic [CW-1:0]    offs [NSLOT];

  assign faw_x   = CW'(faw);
  assign two_faw = faw_x << 1;
  assign rrd_x   = CW'(rrd);
  assign half    = cyc >= two_faw;
  assign c1      = half ? cyc - two_faw : cyc;
  assign qtr     = c1 >= faw_x;
  assign c2      = qtr ? c1 - faw_x : c1;

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    logic [CW-1:0] start;
    assign start   = CW'(k) * rrd_x;
    assign hit[k]  = (c2 >= start) && (c2 < start + rrd_x);
    assign offs[k] = c2 - start;
  end

  logic [2:0]    kidx;
  logic [CW-1:0] off;
  always_comb begin
    kidx = 3'(NSLOT);
    off  = '0;
    for (int k = 0; k < NSLOT; k++) begin
      if (hit[k]) begin
        kidx = 3'(k);
        off  = offs[k];
      end
    end
  end

  always_comb begin
    slot.act  = (kidx != 3'(NSLOT)) && (off == '0);
    slot.rd   = (kidx != 3'(NSLOT)) && (off == CW'(1));
    slot.bank = {qtr, (kidx == 3'(NSLOT)) ? 2'd3 : kidx[1:0]};
    slot.sub  = (half ? 5'd10 : 5'd0) + (qtr ? 5'd5 : 5'd0) + 5'(kidx);
    slot.ones = qtr ^ kidx[0] ^ half;
  end
endmodule

// File: rtl/rdcur_cmd_drive.sv
module rdcur_cmd_drive
  import rdcur_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int BURST  = 4,
  localparam int SW = $clog2(BURST + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              running,
  input  slot_t             slot,
  output logic [3:0]        cmd,
  output logic [2:0]        bank,
  output logic [ADDR_W-1:0] addr,
  output logic              a10,
  output logic [7:0]        data_tag,
  output logic [4:0]        sub_idx,
  output logic              strobe_act
);
  logic [SW-1:0] burst_cnt;
  logic          rd_now;

  assign rd_now = running && slot.rd;

  always_ff @(posedge clk) begin
    if (!rst_n || !running) burst_cnt <= '0;
    else if (rd_now)        burst_cnt <= SW'(BURST - 1);
    else if (burst_cnt != '0) burst_cnt <= burst_cnt - SW'(1);
  end

  assign strobe_act = running && (rd_now || burst_cnt != '0);

  always_comb begin
    cmd      = CMD_DES;
    bank     = '0;
    addr     = '0;
    a10      = 1'b0;
    data_tag = TAG_ZERO;
    sub_idx  = '0;
    if (running) begin
      if (slot.act)     cmd = CMD_ACT;
      else if (slot.rd) cmd = CMD_RDA;
      bank     = slot.bank;
      addr     = slot.ones ? '1 : '0;
      a10      = slot.rd;
      data_tag = slot.ones ? TAG_ALT : TAG_ZERO;
      sub_idx  = slot.sub;
    end
  end
endmodule

// File: rtl/rdcur_pattern_gen.sv
module rdcur_pattern_gen
  import rdcur_pkg::*;
#(
  parameter int RRD_W  = 6,
  parameter int FAW_W  = 8,
  parameter int ADDR_W = 4,
  parameter int BURST  = 4,
  localparam int CW = FAW_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [RRD_W-1:0]  rrd_in,
  input  logic [FAW_W-1:0]  faw_in,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [2:0]        bank,
  output logic [ADDR_W-1:0] addr,
  output logic              a10,
  output logic [7:0]        data_tag,
  output logic              dm,
  output logic              strobe_act,
  output logic              cfg_err,
  output logic [4:0]        sub_idx,
  output logic [CW-1:0]     loop_cyc
);
  logic             running;
  logic [RRD_W-1:0] rrd_q;
  logic [FAW_W-1:0] faw_q;
  slot_t            slot;
  logic [3:0]       cmd;

  rdcur_loop_ctrl #(.RRD_W(RRD_W), .FAW_W(FAW_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .en(en), .rrd_in(rrd_in), .faw_in(faw_in),
    .running(running), .cyc(loop_cyc), .rrd_q(rrd_q), .faw_q(faw_q),
    .cfg_err(cfg_err)
  );

  rdcur_slot_decode #(.RRD_W(RRD_W), .FAW_W(FAW_W)) u_dec (
    .cyc(loop_cyc), .rrd(rrd_q), .faw(faw_q), .slot(slot)
  );

  rdcur_cmd_drive #(.ADDR_W(ADDR_W), .BURST(BURST)) u_drv (
    .clk(clk), .rst_n(rst_n), .running(running), .slot(slot),
    .cmd(cmd), .bank(bank), .addr(addr), .a10(a10), .data_tag(data_tag),
    .sub_idx(sub_idx), .strobe_act(strobe_act)
  );

  assign {cs_n, ras_n, cas_n, we_n} = cmd;
  assign dm = 1'b0;
endmodule

// File: rtl/rdcur_pattern_gen_chk.sv
module rdcur_pattern_gen_chk #(
  parameter int ADDR_W = 4,
  parameter int CW = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [2:0]        bank,
  input logic [ADDR_W-1:0] addr,
  input logic              a10,
  input logic [7:0]        data_tag,
  input logic              strobe_act,
  input logic              cfg_err,
  input logic [4:0]        sub_idx,
  input logic [CW-1:0]     loop_cyc
);
  logic [3:0] c;
  assign c = {cs_n, ras_n, cas_n, we_n};

  p_des_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> (c == 4'b1000 && loop_cyc == '0 && !strobe_act));

  p_cyc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_cyc != '0) |-> (loop_cyc == $past(loop_cyc) + CW'(1)));

  p_act_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (c == 4'b0011) |-> ((sub_idx % 5) != 4 &&
      bank == 3'(((sub_idx % 10) / 5) * 4 + (sub_idx % 5))));

  p_a10_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    a10 |-> (c == 4'b0101));

  p_sub_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sub_idx < 5'd20);

  p_pattern_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (data_tag == 8'h33) |-> (addr == '1));

  p_strobe_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (c == 4'b0101) |-> strobe_act);

  p_err_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (c == 4'b1000 && loop_cyc == '0));
endmodule

bind rdcur_pattern_gen rdcur_pattern_gen_chk #(.ADDR_W(ADDR_W), .CW(CW)) i_chk (.*);

// File: tb/test_rdcur_pattern_gen.sv
module test_rdcur_pattern_gen;
  localparam int RRD_W = 6, FAW_W = 8, ADDR_W = 4, CW = FAW_W + 2;

  logic clk = 0, rst_n = 0, en = 0;
  logic [RRD_W-1:0] rrd_in = 0;
  logic [FAW_W-1:0] faw_in = 0;
  logic cs_n, ras_n, cas_n, we_n, a10, dm, strobe_act, cfg_err;
  logic [2:0] bank;
  logic [ADDR_W-1:0] addr;
  logic [7:0] data_tag;
  logic [4:0] sub_idx;
  logic [CW-1:0] loop_cyc;
  int checks = 0, errors = 0;
  bit done = 0;

  rdcur_pattern_gen i_rdcur_pattern_gen (.*);

  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  function automatic int cmd_now();
    return int'({cs_n, ras_n, cas_n, we_n});
  endfunction

  task automatic model(input int cy, input int rrd, input int faw,
                       output int sub, output int cmd, output int bk, output int ones);
    int half, r, q, c2, k, off;
    half = cy / (2 * faw);
    r    = cy % (2 * faw);
    q    = r / faw;
    c2   = r % faw;
    k    = c2 / rrd;
    if (k > 3) k = 4;
    off  = c2 - k * rrd;
    sub  = half * 10 + q * 5 + k;
    ones = ((q * 5 + k) % 2) ^ half;
    cmd  = (k == 4) ? 8 : (off == 0) ? 3 : (off == 1) ? 5 : 8;
    bk   = q * 4 + ((k == 4) ? 3 : k);
  endtask

  task automatic check_idle(input string req);
    chk({req, " cmd"}, cmd_now(), 8);
    chk({req, " cyc"}, int'(loop_cyc), 0);
    chk({req, " sub"}, int'(sub_idx), 0);
    chk({req, " strobe"}, int'(strobe_act), 0);
  endtask

  task automatic run_cfg(input int rrd, input int faw, input int ncyc);
    int len, sub, cmd, bk, ones, s2, c2, b2, o2, st;
    len = 4 * faw;
    @(negedge clk);
    rrd_in = RRD_W'(rrd); faw_in = FAW_W'(faw); en = 1;
    for (int t = 0; t < ncyc; t++) begin
      @(negedge clk);
      model(t % len, rrd, faw, sub, cmd, bk, ones);
      chk("R2 cyc", int'(loop_cyc), t % len);
      chk("R7 sub", int'(sub_idx), sub);
      chk("R3 cmd", cmd_now(), cmd);
      chk("R4 a10", int'(a10), (cmd == 5) ? 1 : 0);
      if (bk < 4) chk("R5 bank", int'(bank), bk);
      else        chk("R6 bank", int'(bank), bk);
      chk("R7 addr", int'(addr), ones ? 15 : 0);
      chk("R7 tag", int'(data_tag), ones ? 8'h33 : 8'h00);
      chk("R8 dm", int'(dm), 0);
      st = 0;
      for (int j = 0; j < 4; j++) begin
        if (t - j >= 0) begin
          model((t - j) % len, rrd, faw, s2, c2, b2, o2);
          if (c2 == 5) st = 1;
        end
      end
      chk("R9 strobe", int'(strobe_act), st);
      chk("R10 err", int'(cfg_err), 0);
    end
    en = 0;
    @(negedge clk);
    check_idle("R11 stop");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R1 reset");
    chk("R8 dm reset", int'(dm), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check_idle("R1 disabled");

    run_cfg(2, 8, 64);
    run_cfg(2, 9, 72);
    run_cfg(3, 12, 96);
    run_cfg(3, 14, 112);
    run_cfg(4, 17, 136);

    // R10: spacing below 2
    @(negedge clk); rrd_in = 1; faw_in = 8; en = 1;
    @(negedge clk);
    chk("R10 err rrd", int'(cfg_err), 1);
    check_idle("R10 no start");
    // inputs become valid while en held: still no start
    rrd_in = 2;
    repeat (3) @(negedge clk);
    chk("R10 err held", int'(cfg_err), 1);
    check_idle("R10 held");
    en = 0;
    @(negedge clk);
    chk("R10 err clear", int'(cfg_err), 0);
    // R10: window one short of 4x spacing
    rrd_in = 3; faw_in = 11; en = 1;
    @(negedge clk);
    chk("R10 err faw", int'(cfg_err), 1);
    check_idle("R10 faw");
    en = 0;
    @(negedge clk);

    // R11: stop mid-loop then restart at zero
    rrd_in = 2; faw_in = 8; en = 1;
    repeat (11) @(negedge clk);
    chk("R11 mid", int'(loop_cyc), 10);
    en = 0;
    @(negedge clk);
    check_idle("R11 drop");
    en = 1;
    @(negedge clk);
    chk("R11 restart cyc", int'(loop_cyc), 0);
    chk("R11 restart cmd", cmd_now(), 3);
    chk("R11 restart bank", int'(bank), 0);
    en = 0;
    @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule